// File: doc/BRIEF.md
# Compare and Capture Channel Unit

This block watches an externally supplied 16-bit free-running count. It holds five compare channels and three capture channels. A compare channel raises its flag when the count arrives at the value stored for that channel. A capture channel copies the count into its register when its strobe pulses, and it raises its flag at the same time.

All eight flags share one byte, and one enable byte sits beside it with the same bit layout. A single interrupt request stays high while any enabled flag is set. Software writes the compare values and reads every register through a byte-wide bus. Each 16-bit value uses two byte addresses, high byte first. A flag is cleared by writing a one to it.

Reads are combinational on the current address. A write takes effect at the clock edge where the write enable is high.

Top module: `occap_timer`

## Requirements
- R1: After reset the flag byte and the enable byte are 0x00, every compare value is 0xFFFF, every capture value is 0x0000 and irq_o is low.
- R2: In the flag and enable bytes, compare channel k (k = 1..5) uses bit 8-k, so channel 1 is bit 7 and channel 5 is bit 3. Capture channel j (j = 1..3) uses bit 3-j, so capture 1 is bit 2 and capture 3 is bit 0.
- R3: A compare flag is set on the clock edge that follows the cycle in which the count changes to that channel's value. This repeats on every pass of the count, including after it wraps from a high value to zero.
- R4: A strobe on cap_stb_i[j-1] copies the present count into capture register j at the clock edge and sets that capture's flag.
- R5: A write to the flag byte clears each flag whose written bit is 1 and which is currently set. Bits written as 0 leave their flags alone. If a new event arrives at the same edge as a clear, the flag stays set.
- R6: A count that holds at a compare value matches only once. After the flag is cleared, it is not set again until the count leaves that value and returns to it.
- R7: Writing the high byte of a compare value blocks that channel's matches until its low byte has been written. The stored value is then {high, low}.
- R8: irq_o is high exactly while (flags AND enables) is nonzero. It follows a write to either byte from the next cycle on.
- R9: The address map is as follows. Compare k has its high byte at 2(k-1) and its low byte at 2(k-1)+1. Capture j has its high byte at 0x0A+2(j-1) and its low byte one above. The enable byte is at 0x10 and the flag byte is at 0x11.
- R10: Capture registers are read-only. A bus write to a capture address leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | External free-running count |
| cap_stb_i | input | 3 | Capture strobes, bit j-1 for capture j |
| wr_en_i | input | 1 | Byte write enable |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume the following about the inputs. The count and the strobes are stable around each clock edge. A compare value is written as a high byte followed by its low byte. The count starts at a value that matches no compare register. The stimulus changes the count, the strobes and the bus only at falling edges. It never steps the count onto 0xFFFF while untouched channels still hold their reset value, and it always completes a compare write with the low byte, except in the case that deliberately checks the blocking window.

// File: rtl/occap_pkg.sv
package occap_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/occap_cmp_ch.sv
module occap_cmp_ch
  import occap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cnt_t  cnt_i,
  input  logic  cnt_moved_i,
  input  logic  wr_hi_i,
  input  logic  wr_lo_i,
  input  byte_t wdata_i,
  output cnt_t  value_o,
  output logic  hit_o
);
  cnt_t value_q;
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '1;
      lock_q  <= 1'b0;
    end else if (wr_hi_i) begin
      value_q[CNT_W-1:BYTE_W] <= wdata_i;
      lock_q                  <= 1'b1;
    end else if (wr_lo_i) begin
      value_q[BYTE_W-1:0] <= wdata_i;
      lock_q              <= 1'b0;
    end
  end

  // match only on arrival at the value, never while a write is half done
  assign hit_o   = !lock_q && cnt_moved_i && (cnt_i == value_q);
  assign value_o = value_q;

  p_hi_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> !hit_o);
  p_single_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (cnt_i != $past(cnt_i)));
endmodule

// File: rtl/occap_cap_ch.sv
module occap_cap_ch
  import occap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t cnt_i,
  input  logic stb_i,
  output cnt_t value_o,
  output logic hit_o
);
  cnt_t value_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    value_q <= '0;
    else if (stb_i) value_q <= cnt_i;
  end

  assign value_o = value_q;
  assign hit_o   = stb_i;

  p_capture_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_i |=> (value_o == $past(cnt_i)));
endmodule

// File: rtl/occap_flags.sv
module occap_flags
  import occap_pkg::*;
#(
  parameter int FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic              wr_en_reg_i,
  input  logic              wr_flag_reg_i,
  input  byte_t             wdata_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] en_o,
  output logic              irq_o
);
  logic [FLAG_W-1:0] flags_q, en_q, clr;

  assign clr = wr_flag_reg_i ? (wdata_i[FLAG_W-1:0] & flags_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | set_i;
      if (wr_en_reg_i) en_q <= wdata_i[FLAG_W-1:0];
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = |(flags_q & en_q);

  p_mask_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_reg_i && wdata_i == '0) |=> !irq_o);

  for (genvar b = 0; b < FLAG_W; b++) begin : g_chk
    p_flag_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_q[b]) |-> $past(set_i[b]));
    p_clear_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_q[b]) |-> $past(wr_flag_reg_i && wdata_i[b]));
  end
endmodule

// File: rtl/occap_timer.sv
module occap_timer
  import occap_pkg::*;
#(
  parameter int NUM_CMP = 5,
  parameter int NUM_CAP = 3,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NUM_CAP-1:0] cap_stb_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BYTE_W-1:0]  wdata_i,
  output logic [BYTE_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int FLAG_W   = NUM_CMP + NUM_CAP;
  localparam int CAP_BASE = 2 * NUM_CMP;
  localparam int EN_ADDR  = 2 * FLAG_W;
  localparam int FLG_ADDR = EN_ADDR + 1;

  cnt_t              cnt_q;
  logic              cnt_moved;
  cnt_t              cmp_val [NUM_CMP];
  cnt_t              cap_val [NUM_CAP];
  logic [NUM_CMP-1:0] cmp_hit;
  logic [NUM_CAP-1:0] cap_hit;
  logic [FLAG_W-1:0]  set_vec, flags, en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_i;
  end
  assign cnt_moved = (cnt_i != cnt_q);

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    occap_cmp_ch u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt_i),
      .cnt_moved_i(cnt_moved),
      .wr_hi_i    (wr_en_i && addr_i == ADDR_W'(2*k)),
      .wr_lo_i    (wr_en_i && addr_i == ADDR_W'(2*k+1)),
      .wdata_i    (wdata_i),
      .value_o    (cmp_val[k]),
      .hit_o      (cmp_hit[k])
    );
    assign set_vec[FLAG_W-1-k] = cmp_hit[k];
  end

  for (genvar j = 0; j < NUM_CAP; j++) begin : g_cap
    occap_cap_ch u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt_i),
      .stb_i  (cap_stb_i[j]),
      .value_o(cap_val[j]),
      .hit_o  (cap_hit[j])
    );
    assign set_vec[NUM_CAP-1-j] = cap_hit[j];
  end

  occap_flags #(.FLAG_W(FLAG_W)) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_vec),
    .wr_en_reg_i  (wr_en_i && addr_i == ADDR_W'(EN_ADDR)),
    .wr_flag_reg_i(wr_en_i && addr_i == ADDR_W'(FLG_ADDR)),
    .wdata_i      (wdata_i),
    .flags_o      (flags),
    .en_o         (en),
    .irq_o        (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (addr_i == ADDR_W'(2*k))   rdata_o = cmp_val[k][CNT_W-1:BYTE_W];
      if (addr_i == ADDR_W'(2*k+1)) rdata_o = cmp_val[k][BYTE_W-1:0];
    end
    for (int j = 0; j < NUM_CAP; j++) begin
      if (addr_i == ADDR_W'(CAP_BASE+2*j))   rdata_o = cap_val[j][CNT_W-1:BYTE_W];
      if (addr_i == ADDR_W'(CAP_BASE+2*j+1)) rdata_o = cap_val[j][BYTE_W-1:0];
    end
    if (addr_i == ADDR_W'(EN_ADDR))  rdata_o = BYTE_W'(en);
    if (addr_i == ADDR_W'(FLG_ADDR)) rdata_o = BYTE_W'(flags);
  end

  p_cap_read_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(CAP_BASE) && !cap_stb_i[0])
      |=> $stable(cap_val[0]));
endmodule

// File: tb/occap_timer_test.sv
module occap_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] cnt = 16'h0000;
  logic [2:0] stb = 3'b000;
  logic       we = 1'b0;
  logic [4:0] addr = 5'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  occap_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cap_stb_i(stb),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] IRQ_SEL = 8'hFF;

  task automatic expect_rd(input logic [7:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    if (sel != IRQ_SEL) addr = sel[4:0];
    sb_q.push_back('{sel, exp, tag});
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    @(negedge clk);
    cnt = v;
  endtask

  task automatic strobe(input int j);
    @(negedge clk);
    stb[j] = 1'b1;
    @(negedge clk);
    stb = 3'b000;
  endtask

  // monitor: pops expected items a quarter period after each falling edge
  always @(negedge clk) begin
    #5;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      act = (it.sel == IRQ_SEL) ? {7'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(8'h11, 8'h00, "R1 flags");
    expect_rd(8'h10, 8'h00, "R1 enables");
    expect_rd(8'h00, 8'hFF, "R1 cmp1 hi");
    expect_rd(8'h09, 8'hFF, "R1 cmp5 lo");
    expect_rd(8'h0A, 8'h00, "R1 cap1 hi");
    expect_rd(IRQ_SEL, 8'h00, "R1 irq");

    // R3/R2/R9 compare 1 at 0x1234, enabled at bit 7
    wr(5'h00, 8'h12);
    wr(5'h01, 8'h34);
    expect_rd(8'h00, 8'h12, "R9 cmp1 hi");
    expect_rd(8'h01, 8'h34, "R9 cmp1 lo");
    wr(5'h10, 8'h80);
    set_cnt(16'h1233);
    expect_rd(8'h11, 8'h00, "R3 before match");
    set_cnt(16'h1234);
    expect_rd(8'h11, 8'h80, "R3 R2 cmp1 flag bit7");
    expect_rd(IRQ_SEL, 8'h01, "R8 irq on enabled flag");

    // R6 hold at match, clear, no re-set
    wr(5'h11, 8'h80);
    expect_rd(8'h11, 8'h00, "R5 clear bit7");
    expect_rd(IRQ_SEL, 8'h00, "R8 irq drops");
    repeat (3) @(negedge clk);
    expect_rd(8'h11, 8'h00, "R6 held count no rematch");

    // R3 wrap, compare 5 at bit 3
    wr(5'h08, 8'h00);
    wr(5'h09, 8'h05);
    set_cnt(16'hFFFE);
    set_cnt(16'h0000);
    set_cnt(16'h0004);
    set_cnt(16'h0005);
    expect_rd(8'h11, 8'h08, "R3 R2 cmp5 after wrap");
    expect_rd(IRQ_SEL, 8'h00, "R8 not enabled");
    wr(5'h10, 8'h08);
    expect_rd(IRQ_SEL, 8'h01, "R8 enable write raises irq");
    wr(5'h11, 8'h80);
    expect_rd(8'h11, 8'h08, "R5 write to clear flag ignored");
    wr(5'h11, 8'h08);
    expect_rd(8'h11, 8'h00, "R5 clear bit3");
    set_cnt(16'h1000);
    set_cnt(16'h0005);
    expect_rd(8'h11, 8'h08, "R3 second pass");
    wr(5'h11, 8'hFF);

    // R4 captures
    set_cnt(16'hABCD);
    strobe(0);
    expect_rd(8'h0A, 8'hAB, "R4 cap1 hi");
    expect_rd(8'h0B, 8'hCD, "R4 cap1 lo");
    expect_rd(8'h11, 8'h04, "R4 R2 cap1 flag bit2");
    wr(5'h0A, 8'h55);
    expect_rd(8'h0A, 8'hAB, "R10 cap write ignored");
    wr(5'h11, 8'hFF);
    set_cnt(16'h0101);
    strobe(2);
    expect_rd(8'h0E, 8'h01, "R4 cap3 hi");
    expect_rd(8'h0F, 8'h01, "R4 cap3 lo");
    expect_rd(8'h11, 8'h01, "R4 R2 cap3 flag bit0");
    wr(5'h11, 8'hFF);

    // R7 high byte blocks until low byte
    wr(5'h02, 8'h20);
    set_cnt(16'h20FF);
    expect_rd(8'h11, 8'h00, "R7 blocked after hi write");
    wr(5'h03, 8'h10);
    expect_rd(8'h02, 8'h20, "R7 cmp2 hi");
    expect_rd(8'h03, 8'h10, "R7 cmp2 lo");
    set_cnt(16'h2010);
    expect_rd(8'h11, 8'h40, "R7 R2 cmp2 match bit6");

    // R5 set wins over simultaneous clear
    set_cnt(16'h2000);
    @(negedge clk);
    cnt = 16'h2010; addr = 5'h11; wdata = 8'h40; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    expect_rd(8'h11, 8'h40, "R5 set wins over clear");
    expect_rd(8'h10, 8'h08, "R9 enable readback");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule